// File: doc/BRIEF.md
# Text Row Scanline Sequencer

This block sets the scanline timing of a character text layer. Every horizontal-sync strobe moves it one scanline on within the current text row. It reports which text row is being drawn, which line of the 16-line glyph the character generator must fetch, and whether the scanline is blank. A row can be taller than the glyph, so the scanlines past the glyph come out blank. A starting offset loaded at frame start lets the glyph sit centred in a tall row.

A 5-bit scroll count turns the row contents around by a number of scanlines. The shift is taken modulo the row height. In 16-line rows a count of 16 therefore looks the same as 0, and in 20-line rows the picture keeps moving up to a count of 19. The row height, offset and scroll values are plain input ports and are read live at every strobe.

Top module: `text_row_seq`

## Requirements
- R1: While reset is active, and after it, `row_idx`, `glyph_line` and `blank` are all 0.
- R2: Only a strobe on `hsync` or `fstart` changes the outputs. The new values show one clock after the strobe. With no strobe, every output holds its value.
- R3: `row_height` holds the number of scanlines per row minus one. A value of 0 gives one-line rows, 15 gives 16, 19 gives 20 and 31 gives 32.
- R4: On an `hsync` strobe at the last scanline of a row, the line counter returns to 0 and `row_idx` goes up by one. On any other `hsync` strobe, the line counter goes up by one.
- R5: An `fstart` strobe clears `row_idx` and loads the line counter from `start_off`. When `fstart` and `hsync` are high together, `fstart` wins.
- R6: The display position is the line counter after the scroll has been applied. At positions 0 to 15, `glyph_line` equals the position and `blank` is 0. At positions 16 and above, `blank` is 1 and `glyph_line` is 0.
- R7: The display position is (line counter + (`scroll` mod H)) mod H, where H is the number of lines per row. In 16-line rows a scroll of 0x10 gives the same output as 0x00, and 0x11 shifts the display by one line. In 20-line rows a scroll of 0x13 still shifts the display.
- R8: A 20-line row (`row_height` = 19) with `start_off` = 2 holds 16 glyph lines and 4 blank lines. The row index reaches 25 after 498 strobes following `fstart`, which is 500 counted lines.
- R9: `row_idx` wraps modulo 2^ROW_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | One-cycle strobe per scanline |
| fstart | input | 1 | One-cycle frame-start strobe |
| row_height | input | 5 | Number of scanlines per row minus one |
| start_off | input | 5 | Line counter value loaded at frame start |
| scroll | input | 5 | Scroll count in scanlines |
| row_idx | output | ROW_W | Current text row |
| glyph_line | output | 4 | Glyph line address for the character generator |
| blank | output | 1 | Scanline is blank |

## Verification
The assertions check the cycle-level rules on every clock:
- outputs hold when there is no strobe;
- the row index either steps by one or stays put on an `hsync` strobe;
- the row index is cleared after `fstart`;
- the counter wraps at the row end;
- `glyph_line` is zero whenever `blank` is set.

Some behaviour only the bench scenarios can show. This covers the arithmetic results: the scroll wrapping for 16-line and 20-line rows, the centred 20-line layout over a whole frame, the edge heights of 1 and 32 lines, and the wrap of the row index.

// File: rtl/text_row_seq.sv
module text_row_seq #(
  parameter int ROW_W   = 6,
  parameter int LINE_W  = 5,
  parameter int GLYPH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               fstart,
  input  logic [LINE_W-1:0]  row_height,
  input  logic [LINE_W-1:0]  start_off,
  input  logic [LINE_W-1:0]  scroll,
  output logic [ROW_W-1:0]   row_idx,
  output logic [GLYPH_W-1:0] glyph_line,
  output logic               blank
);
  localparam int POS_W = LINE_W + 1;
  localparam logic [POS_W-1:0] GLYPH_LINES = POS_W'(1 << GLYPH_W);

  logic [LINE_W-1:0] lc, lc_nx;
  logic [ROW_W-1:0]  row_nx;
  logic [POS_W-1:0]  lines, eff, pos;
  logic              row_end;

  assign lines   = {1'b0, row_height} + POS_W'(1);
  assign row_end = lc >= row_height;
  assign eff     = {1'b0, scroll} % lines;
  assign pos     = ({1'b0, lc_nx} + eff) % lines;

  always_comb begin
    lc_nx  = lc;
    row_nx = row_idx;
    if (fstart) begin
      lc_nx  = start_off;
      row_nx = '0;
    end else if (hsync) begin
      if (row_end) begin
        lc_nx  = '0;
        row_nx = row_idx + ROW_W'(1);
      end else begin
        lc_nx = lc + LINE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc         <= '0;
      row_idx    <= '0;
      glyph_line <= '0;
      blank      <= 1'b0;
    end else if (fstart || hsync) begin
      lc         <= lc_nx;
      row_idx    <= row_nx;
      blank      <= pos >= GLYPH_LINES;
      glyph_line <= (pos >= GLYPH_LINES) ? '0 : pos[GLYPH_W-1:0];
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync && !fstart |=> $stable(row_idx) && $stable(glyph_line) && $stable(blank)); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hsync && !fstart |=> (row_idx == $past(row_idx)) || (row_idx == $past(row_idx) + ROW_W'(1))); // R4
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |=> row_idx == '0 && lc == $past(start_off)); // R5
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    hsync && !fstart && row_end |=> lc == '0); // R4
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> glyph_line == '0); // R6
endmodule

// File: tb/tb_text_row_seq.sv
module tb_text_row_seq;
  logic clk = 0, rst_n = 0, hsync = 0, fstart = 0;
  logic [4:0] row_height = 0, start_off = 0, scroll = 0;
  logic [5:0] row_idx;
  logic [3:0] glyph_line;
  logic blank;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  text_row_seq dut (.clk, .rst_n, .hsync, .fstart, .row_height, .start_off,
                    .scroll, .row_idx, .glyph_line, .blank);

  // fields: height, offset, scroll, strobes, exp row, exp glyph, exp blank
  localparam bit [34:0] VEC [15] = '{
    {5'd15, 5'd0, 5'd0,  9'd0,   6'd0,  4'd0, 1'b0},
    {5'd15, 5'd0, 5'd0,  9'd5,   6'd0,  4'd5, 1'b0},
    {5'd15, 5'd0, 5'd0,  9'd16,  6'd1,  4'd0, 1'b0},
    {5'd15, 5'd0, 5'd16, 9'd3,   6'd0,  4'd3, 1'b0},
    {5'd15, 5'd0, 5'd17, 9'd3,   6'd0,  4'd4, 1'b0},
    {5'd19, 5'd2, 5'd0,  9'd14,  6'd0,  4'd0, 1'b1},
    {5'd19, 5'd2, 5'd0,  9'd18,  6'd1,  4'd0, 1'b0},
    {5'd19, 5'd2, 5'd0,  9'd498, 6'd25, 4'd0, 1'b0},
    {5'd19, 5'd0, 5'd19, 9'd1,   6'd0,  4'd0, 1'b0},
    {5'd19, 5'd0, 5'd19, 9'd0,   6'd0,  4'd0, 1'b1},
    {5'd0,  5'd0, 5'd0,  9'd3,   6'd3,  4'd0, 1'b0},
    {5'd31, 5'd0, 5'd0,  9'd20,  6'd0,  4'd0, 1'b1},
    {5'd31, 5'd0, 5'd0,  9'd32,  6'd1,  4'd0, 1'b0},
    {5'd19, 5'd0, 5'd5,  9'd12,  6'd0,  4'd0, 1'b1},
    {5'd0,  5'd0, 5'd0,  9'd70,  6'd6,  4'd0, 1'b0}
  };

  task automatic check(string req, logic [5:0] er, logic [3:0] eg, logic eb);
    checks++;
    if (row_idx !== er || glyph_line !== eg || blank !== eb) begin
      fails++;
      $display("FAIL %s: row=%0d glyph=%0d blank=%0b, expected row=%0d glyph=%0d blank=%0b",
               req, row_idx, glyph_line, blank, er, eg, eb);
    end
  endtask

  task automatic strobe(logic fs, logic hs);
    @(negedge clk); fstart = fs; hsync = hs;
    @(negedge clk); fstart = 0; hsync = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 0, 0, 0);

    for (int i = 0; i < 15; i++) begin
      row_height = VEC[i][34:30]; start_off = VEC[i][29:25]; scroll = VEC[i][24:20];
      strobe(1, 0);
      for (int n = 0; n < int'(VEC[i][19:11]); n++) strobe(0, 1);
      check($sformatf("R3 R4 R6 R7 R8 R9 vector %0d", i), VEC[i][10:5], VEC[i][4:1], VEC[i][0]);
    end

    // R2: timing and hold
    row_height = 15; start_off = 0; scroll = 0;
    strobe(1, 0);
    strobe(0, 1); strobe(0, 1);
    repeat (10) @(negedge clk);
    check("R2 hold without strobe", 0, 2, 0);
    @(negedge clk); hsync = 1;
    #1 check("R2 no change before edge", 0, 2, 0);
    @(negedge clk); hsync = 0;
    check("R2 change one clock after strobe", 0, 3, 0);
    row_height = 3; scroll = 1;
    repeat (5) @(negedge clk);
    check("R2 register change alone has no effect", 0, 3, 0);

    // R5: fstart wins over hsync, loads offset
    row_height = 19; scroll = 0; start_off = 2;
    strobe(0, 1);
    strobe(1, 1);
    check("R5 fstart over hsync", 0, 2, 0);
    start_off = 17;
    strobe(1, 0);
    check("R5 offset into blank band", 0, 0, 1);

    // R8: walk one centred 20-line row line by line
    start_off = 2;
    strobe(1, 0);
    for (int n = 0; n < 20; n++) begin
      automatic int l = (2 + n) % 20;
      automatic logic [5:0] er = (2 + n) / 20;
      check("R8 line walk", er, (l < 16) ? 4'(l) : 4'd0, l >= 16);
      strobe(0, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule